// File: doc/BRIEF.md
# Slow-Clock Synchronized Free-Running Timer

This block keeps a 32-bit up-counter running from a slow (nominally 32 kHz) clock and lets a host on a faster bus clock read it at any time. The counter advances on the falling edge of the slow clock. An active-low asynchronous power-on reset holds it at its reset value. Once the reset is released, the counter waits a fixed number of slow periods before its first step. It then runs forever, rolling over from all-ones to zero.

The count reaches the bus domain in Gray code. Each increment flips a single bit, so a bus-side sample taken mid-change is always either the old value or the new one. The bus side is a read-only slave with a 16-bit address and a 32-bit data bus. It serves 32-bit reads of the whole count and 16-bit reads of either half. A 16-bit read of the lower half also latches the whole count. A following read of the upper half returns the top of that same latched value, so two narrow reads form one coherent value even when the counter carries between them. Writes get a normal response and change nothing.

Top module: `slow_sync_timer`

## Requirements
- R1: The count is 32 bits wide and rises by exactly one on each falling edge of `slow_clk` once counting has begun.
- R2: While `por_n` is low the count is held at its reset value (0 by default) and the slave gives no response. The first read after release returns the reset value.
- R3: After `por_n` rises, the first three falling edges of `slow_clk` leave the count unchanged. The fourth falling edge raises it by one.
- R4: After 0xFFFFFFFF the count rolls over to 0x00000000 and keeps counting.
- R5: While the slow clock runs, successive 32-bit reads never go backwards, never exceed the slow-domain count, and never show a torn value. Once the slow clock has been idle for eight bus cycles, a read returns the exact count.
- R6: A request is accepted on the rising `bus_clk` edge where `req_valid` is high. `rsp_valid` is high for exactly the following cycle, carrying `rsp_rdata`, and is low in cycles with no accepted request.
- R7: A read with `req_size` = 2'b10 (word) at address 0x0010 returns the full 32-bit count.
- R8: A read with `req_size` = 2'b01 (half) at 0x0010 returns count bits 15:0 on `rsp_rdata[15:0]` and latches the full count into a snapshot. A half read at 0x0012 returns snapshot bits 31:16 on `rsp_rdata[31:16]`. All other data bits are zero.
- R9: Byte reads (`req_size` = 2'b00), the reserved size 2'b11, misaligned word reads and half reads at odd addresses return zero.
- R10: Reads of any address outside the count word (0x0010 to 0x0013) return zero.
- R11: A write (`req_write` = 1) gets a response with zero data and changes neither the count nor the snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock for the register slave |
| slow_clk | input | 1 | Slow counting clock; the count steps on its falling edge |
| por_n | input | 1 | Asynchronous active-low power-on reset for both domains |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write (ignored), 0 = read |
| req_addr | input | 16 | Byte address of the access |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| req_wdata | input | 32 | Write data (discarded) |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, zero for writes and unsupported reads |

## Verification
The bench stops the slow clock at chosen points so that the exact count is known. It then probes the three-edge start delay: a design that starts one edge early or late reads 1 or 0 at the wrong step. A second instance, reset just below all-ones, is read in halves across the rollover. A design without the low-half snapshot returns 0x0000 for the upper half instead of 0xFFFF. Reads run alongside a moving slow clock to catch a binary crossing that lets a torn or backward value through. Random mixes of writes, byte and odd-address accesses, and unmapped addresses show whether any of them leak data or disturb the snapshot.

// File: rtl/slowtmr_pkg.sv
`timescale 1ns/1ps
package slowtmr_pkg;
  localparam int CNT_W  = 32;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // binary to reflected Gray code
  function automatic logic [CNT_W-1:0] bin_to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary, prefix XOR from the top bit down
  function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/slowtmr_rst_sync.sv
`timescale 1ns/1ps
module slowtmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/slowtmr_counter.sv
`timescale 1ns/1ps
module slowtmr_counter
  import slowtmr_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_VAL  = '0,
  parameter int               START_WAIT = 3
) (
  input  logic             slow_clk,
  input  logic             por_n,
  output logic [CNT_W-1:0] gray_o,
  output logic             running_o
);
  localparam int WAIT_W = $clog2(START_WAIT + 2);
  localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(START_WAIT);

  logic [WAIT_W-1:0] wait_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_next;
  logic [CNT_W-1:0]  gray_q;
  logic              running;

  assign running  = (wait_q == WAIT_END);
  assign cnt_next = cnt_q + 1'b1;

  // start delay: counts slow falling edges after reset release
  always_ff @(negedge slow_clk or negedge por_n) begin
    if (!por_n)        wait_q <= '0;
    else if (!running) wait_q <= wait_q + 1'b1;
  end

  always_ff @(negedge slow_clk or negedge por_n) begin
    if (!por_n)       cnt_q <= RESET_VAL;
    else if (running) cnt_q <= cnt_next;
  end

  // Gray value is registered directly so the crossing sees a glitch-free bus
  always_ff @(negedge slow_clk or negedge por_n) begin
    if (!por_n)       gray_q <= bin_to_gray(RESET_VAL);
    else if (running) gray_q <= bin_to_gray(cnt_next);
  end

  assign gray_o    = gray_q;
  assign running_o = running;

  // R1
  step_by_one_chk: assert property (@(negedge slow_clk) disable iff (!por_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  hold_in_wait_chk: assert property (@(negedge slow_clk) disable iff (!por_n)
    !running |-> (cnt_q == RESET_VAL));

  // R5
  gray_matches_count_chk: assert property (@(negedge slow_clk) disable iff (!por_n)
    gray_to_bin(gray_q) == cnt_q);
endmodule

// File: rtl/slowtmr_gray_sync.sv
`timescale 1ns/1ps
module slowtmr_gray_sync
  import slowtmr_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_VAL = '0,
  parameter int               STAGES    = 2
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] GRAY_RST = bin_to_gray(RESET_VAL);

  logic [CNT_W-1:0] stage_q [STAGES];
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] gray_synced;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= GRAY_RST;
    end else begin
      stage_q[0] <= gray_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign gray_synced = stage_q[STAGES-1];

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) bin_q <= RESET_VAL;
    else            bin_q <= gray_to_bin(gray_synced);
  end

  assign count_o = bin_q;

  // R5
  gray_one_bit_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $countones(gray_synced ^ $past(gray_synced)) <= 1);

  // R5
  bus_count_monotonic_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bin_q == $past(bin_q)) || (bin_q == $past(bin_q) + 1'b1));
endmodule

// File: rtl/slowtmr_regs.sv
`timescale 1ns/1ps
module slowtmr_regs
  import slowtmr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CNT_OFS = 16'h0010
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [CNT_W-1:0]  count_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  acc_size_e         size;
  logic              rd_req;
  logic              word_hit;
  logic              lo_read;
  logic              hi_read;
  logic              wd_read;
  logic [CNT_W-1:0]  snap_q;
  logic [DATA_W-1:0] rdata_d;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign size     = acc_size_e'(req_size);
  assign rd_req   = req_valid && !req_write;
  assign word_hit = (req_addr[ADDR_W-1:2] == CNT_OFS[ADDR_W-1:2]);
  assign wd_read  = rd_req && word_hit && (size == SZ_WORD) && (req_addr[1:0] == 2'b00);
  assign lo_read  = rd_req && word_hit && (size == SZ_HALF) && (req_addr[1:0] == 2'b00);
  assign hi_read  = rd_req && word_hit && (size == SZ_HALF) && (req_addr[1:0] == 2'b10);

  always_comb begin
    rdata_d = '0;
    if (wd_read)      rdata_d = count_i;
    else if (lo_read) rdata_d = {{HALF_W{1'b0}}, count_i[HALF_W-1:0]};
    else if (hi_read) rdata_d = {snap_q[CNT_W-1:HALF_W], {HALF_W{1'b0}}};
  end

  // snapshot of the whole count, taken by the lower-half read
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n)   snap_q <= '0;
    else if (lo_read) snap_q <= count_i;
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R11
  write_keeps_snap_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (req_valid && req_write) |=> $stable(snap_q));

  // R9
  byte_read_zero_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (rsp_valid && ($past(req_size) == 2'b00)) |-> (rsp_rdata == '0));

  // R8
  half_one_lane_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (rsp_valid && ($past(req_size) == 2'b01)) |->
      ((rsp_rdata[DATA_W-1:HALF_W] == '0) || (rsp_rdata[HALF_W-1:0] == '0)));

  // R11
  write_data_zero_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (rsp_valid && $past(req_write)) |-> (rsp_rdata == '0));
endmodule

// File: rtl/slow_sync_timer.sv
`timescale 1ns/1ps
module slow_sync_timer
  import slowtmr_pkg::*;
#(
  parameter logic [CNT_W-1:0]  RESET_VAL   = '0,
  parameter int                START_WAIT  = 3,
  parameter logic [ADDR_W-1:0] CNT_OFS     = 16'h0010,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2
) (
  input  logic        bus_clk,
  input  logic        slow_clk,
  input  logic        por_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  logic             bus_rst_n;
  logic [CNT_W-1:0] slow_gray;
  logic             slow_running;
  logic [CNT_W-1:0] bus_count;
  logic             unused_inputs;

  // write data is accepted and dropped
  assign unused_inputs = ^{req_wdata, slow_running};

  slowtmr_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (bus_clk),
    .arst_n (por_n),
    .rst_n  (bus_rst_n)
  );

  slowtmr_counter #(.RESET_VAL(RESET_VAL), .START_WAIT(START_WAIT)) u_counter (
    .slow_clk  (slow_clk),
    .por_n     (por_n),
    .gray_o    (slow_gray),
    .running_o (slow_running)
  );

  slowtmr_gray_sync #(.RESET_VAL(RESET_VAL), .STAGES(SYNC_STAGES)) u_gray_sync (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .gray_i    (slow_gray),
    .count_o   (bus_count)
  );

  slowtmr_regs #(.CNT_OFS(CNT_OFS)) u_regs (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .count_i   (bus_count),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R2
  no_rsp_in_reset_chk: assert property (@(posedge bus_clk)
    !bus_rst_n |-> !rsp_valid);
endmodule

// File: tb/slow_sync_timer_bench.sv
`timescale 1ns/1ps
module slow_sync_timer_bench;
  localparam logic [31:0] WRAP_BASE = 32'hFFFF_FFFA;
  localparam int          WAIT_N    = 3;

  logic        bus_clk   = 1'b0;
  logic        slow_clk  = 1'b1;
  logic        por_n     = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr  = '0;
  logic [1:0]  req_size  = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid_a, rsp_valid_b;
  logic [31:0] rsp_rdata_a, rsp_rdata_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model of the slow domain
  int unsigned wait_m = 0;
  logic [31:0] steps_m = '0;
  logic [31:0] snap_a_m = '0;
  logic [31:0] snap_b_m = '0;
  logic        got_va, got_vb;
  logic [31:0] got_a, got_b;

  always #10 bus_clk = ~bus_clk;

  slow_sync_timer u_slow_sync_timer (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .por_n(por_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_a), .rsp_rdata(rsp_rdata_a));

  slow_sync_timer #(.RESET_VAL(WRAP_BASE)) u_slow_sync_timer_wrap (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .por_n(por_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_b), .rsp_rdata(rsp_rdata_b));

  function automatic logic [31:0] live_a();
    return steps_m;
  endfunction

  function automatic logic [31:0] live_b();
    return WRAP_BASE + steps_m;
  endfunction

  // expected read data from the requirement text
  function automatic logic [31:0] exp_rd(input logic w, input logic [15:0] a,
                                         input logic [1:0] sz, input logic [31:0] live,
                                         input logic [31:0] snap);
    if (w) return 32'h0;
    if (sz == 2'b10 && a == 16'h0010) return live;
    if (sz == 2'b01 && a == 16'h0010) return {16'h0, live[15:0]};
    if (sz == 2'b01 && a == 16'h0012) return {snap[31:16], 16'h0};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic slow_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      #130 slow_clk = 1'b0;
      if (por_n) begin
        if (wait_m < WAIT_N) wait_m++;
        else steps_m = steps_m + 1;
      end
      #130 slow_clk = 1'b1;
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge bus_clk);
  endtask

  task automatic bus_op(input logic w, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd);
    @(negedge bus_clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge bus_clk);
    got_va = rsp_valid_a; got_vb = rsp_valid_b;
    got_a  = rsp_rdata_a; got_b  = rsp_rdata_b;
    req_valid = 1'b0; req_write = 1'b0;
    if (!w && sz == 2'b01 && a == 16'h0010) begin
      snap_a_m = live_a();
      snap_b_m = live_b();
    end
  endtask

  // watchdog
  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    void'($urandom(32'd20240611));

    // reset phase: R2
    slow_ticks(2);
    bus_op(1'b0, 16'h0010, 2'b10, '0);
    chk("R2 no response in reset", {31'h0, got_va}, 32'h0);
    chk("R2 data in reset", got_a, 32'h0);

    // release away from a slow edge
    #50 por_n = 1'b1;
    repeat (4) @(negedge bus_clk);
    settle();
    bus_op(1'b0, 16'h0010, 2'b10, '0);
    chk("R2 reset value main", got_a, 32'h0);
    chk("R2 reset value wrap", got_b, WRAP_BASE);
    chk("R6 response strobe", {31'h0, got_va}, 32'h1);
    @(negedge bus_clk);
    chk("R6 strobe drops", {31'h0, rsp_valid_a}, 32'h0);

    // R3 start delay
    slow_ticks(3); settle();
    bus_op(1'b0, 16'h0010, 2'b10, '0);
    chk("R3 held after three edges", got_a, 32'h0);
    slow_ticks(1); settle();
    bus_op(1'b0, 16'h0010, 2'b10, '0);
    chk("R3 first step on fourth edge", got_a, 32'h1);
    chk("R1 step wrap instance", got_b, WRAP_BASE + 1);

    // R1 several steps
    slow_ticks(4); settle();
    bus_op(1'b0, 16'h0010, 2'b10, '0);
    chk("R1 count after five steps", got_a, 32'h5);
    chk("R4 at all-ones", got_b, 32'hFFFF_FFFF);

    // R8 coherent split read across the rollover
    bus_op(1'b0, 16'h0010, 2'b01, '0);
    chk("R8 low half", got_b, 32'h0000_FFFF);
    chk("R8 low half main", got_a, 32'h0000_0005);
    slow_ticks(2); settle();
    bus_op(1'b0, 16'h0012, 2'b01, '0);
    chk("R8 high half from snapshot", got_b, 32'hFFFF_0000);
    chk("R8 high half main", got_a, 32'h0);
    bus_op(1'b0, 16'h0010, 2'b10, '0);
    chk("R4 rolled over", got_b, 32'h1);
    chk("R7 word read main", got_a, 32'h7);

    // R11 writes ignored
    bus_op(1'b1, 16'h0010, 2'b10, 32'hDEAD_BEEF);
    chk("R11 write response", {31'h0, got_va}, 32'h1);
    chk("R11 write data zero", got_a, 32'h0);
    bus_op(1'b1, 16'h0010, 2'b01, 32'h1234_5678);
    bus_op(1'b0, 16'h0010, 2'b10, '0);
    chk("R11 count unchanged", got_a, 32'h7);
    bus_op(1'b0, 16'h0012, 2'b01, '0);
    chk("R11 snapshot unchanged", got_b, 32'hFFFF_0000);

    // R9 and R10
    bus_op(1'b0, 16'h0010, 2'b00, '0);
    chk("R9 byte read", got_a, 32'h0);
    bus_op(1'b0, 16'h0010, 2'b11, '0);
    chk("R9 reserved size", got_a, 32'h0);
    bus_op(1'b0, 16'h0012, 2'b10, '0);
    chk("R9 misaligned word", got_a, 32'h0);
    bus_op(1'b0, 16'h0011, 2'b01, '0);
    chk("R9 odd half", got_a, 32'h0);
    bus_op(1'b0, 16'h0014, 2'b10, '0);
    chk("R10 unmapped 0x14", got_a, 32'h0);
    bus_op(1'b0, 16'h0000, 2'b10, '0);
    chk("R10 unmapped 0x00", got_a, 32'h0);

    // R5 reads while running
    prev = steps_m;
    fork
      slow_ticks(40);
      begin
        for (int i = 0; i < 200; i++) begin
          bus_op(1'b0, 16'h0010, 2'b10, '0);
          checks++;
          if (got_a < prev || got_a > steps_m) begin
            errors++;
            $display("FAIL R5 running read actual=%h expected range %h..%h", got_a, prev, steps_m);
          end
          prev = got_a;
        end
      end
    join
    settle();
    bus_op(1'b0, 16'h0010, 2'b10, '0);
    chk("R5 exact after idle", got_a, live_a());
    chk("R5 exact after idle wrap", got_b, live_b());

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [15:0] a;
      logic [1:0]  sz;
      logic        w;
      logic [31:0] ea, eb;
      if ($urandom_range(0, 3) == 0) begin
        slow_ticks($urandom_range(1, 3));
        settle();
      end
      case ($urandom_range(0, 5))
        0: a = 16'h0010;
        1: a = 16'h0012;
        2: a = 16'h0011;
        3: a = 16'h0014;
        4: a = 16'h0000;
        default: a = 16'($urandom());
      endcase
      sz = 2'($urandom_range(0, 3));
      w  = ($urandom_range(0, 7) == 0);
      ea = exp_rd(w, a, sz, live_a(), snap_a_m);
      eb = exp_rd(w, a, sz, live_b(), snap_b_m);
      bus_op(w, a, sz, $urandom());
      chk("R6 random strobe", {31'h0, got_va}, 32'h1);
      chk("R7 R8 R9 R10 R11 random main", got_a, ea);
      chk("R7 R8 R9 R10 R11 random wrap", got_b, eb);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule